// File: doc/BRIEF.md
# Key-Protected Watchdog Timer

This block is a watchdog timer that sits on a simple word-addressed register bus. Its settings are guarded twice. A lock stage blocks every configuration write until two fixed 32-bit unlock words have been written in order. The run control and the reaction choice then respond only to exact 32-bit codes. Software unlocks the block, picks a counting tick source, writes a preload that sets the timeout window, and picks a reaction. It then starts the counter by writing the run code.

Once running, the watchdog cannot be stopped short of a reset. The counter counts selected tick enables down from `(preload+1) << 13`. When it reaches zero, the block produces the chosen reaction. That reaction is either a one-cycle reset request or an interrupt line that stays high until reset. Register reads are combinational from the address.

Top module: `kwdt_top`

## Requirements
- R1: After reset the configuration is locked, and the lock status reads 0. While locked, writes to the tick select (0x08), run control (0x0C), reaction (0x10) and preload (0x14) registers change nothing. Reading 0x00 or 0x04 returns the lock status in bits [1:0]: 0 for locked, 1 for half-unlocked, 2 for open.
- R2: Writing 0x68EF3490 to 0x00 moves the lock to half-unlocked from any state. A following write of 0xD172BC5A to 0x04 opens it. Any other value written to either address re-locks, and so does a write to 0x04 that is not made in the half-unlocked state.
- R3: When the lock is open and the watchdog is idle, writing 0xA98559DA to 0x0C starts the counter. The register then reads back 0xA98559DA, and it reads 0x5312ACED while idle. Writing 0x5312ACED, or any other value, while idle leaves the watchdog idle.
- R4: Once running, the watchdog cannot be stopped. A later write of 0x5312ACED to 0x0C is ignored, and the register keeps reading 0xA98559DA.
- R5: The reaction register resets to 0x5. It accepts only the exact 32-bit values 0x5 and 0xA; any other write leaves it unchanged.
- R6: The counter reload is (preload+1)·8192 selected ticks. The preload is 12 bits and resets to 0. With a tick on every cycle, expiry is seen exactly (preload+1)·8192 cycles after the clock edge that accepts the run code.
- R7: With reaction 0x5, expiry raises `rst_req_o` for exactly one cycle, and `irq_o` stays low.
- R8: With reaction 0xA, expiry raises `irq_o`, which then stays high until reset. `rst_req_o` stays low.
- R9: The tick select at 0x08 is 2 bits and resets to 3. It picks which bit of `tick_i` paces the counter, and the other bits have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 5 | Byte address of the register |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i`, combinational |
| tick_i | input | 4 | Candidate count-enable sources |
| irq_o | output | 1 | Interrupt reaction, held until reset |
| rst_req_o | output | 1 | Reset-request reaction, one-cycle pulse |

## Verification
The key checking is tried with several kinds of write. Exact codes are compared with near-miss values, such as a valid code with upper bits set, or an unlock word at the wrong address or in the wrong order. This separates a full 32-bit compare from a partial one, and an ordered lock from a set of independent flags. The timeout is measured to the exact cycle for two preload values, which exposes off-by-one and shift errors. A run paced by a half-rate tick on a non-default select, while the default source is held high, shows that only the selected tick counts. The two reaction codes are run side by side to separate the one-cycle pulse from the held interrupt.

// File: rtl/kwdt_pkg.sv
package kwdt_pkg;

  localparam int ADDR_W = 5;

  localparam logic [31:0] KICK_A_WORD = 32'h68EF_3490;
  localparam logic [31:0] KICK_B_WORD = 32'hD172_BC5A;
  localparam logic [31:0] RUN_CODE    = 32'hA985_59DA;
  localparam logic [31:0] STOP_CODE   = 32'h5312_ACED;

  localparam logic [3:0] REACT_RESET = 4'h5;
  localparam logic [3:0] REACT_IRQ   = 4'hA;

  // word index = addr[4:2]
  typedef enum logic [2:0] {
    IDX_KICK_A  = 3'd0,
    IDX_KICK_B  = 3'd1,
    IDX_TICKSEL = 3'd2,
    IDX_RUN     = 3'd3,
    IDX_REACT   = 3'd4,
    IDX_PRELOAD = 3'd5
  } reg_idx_e;

  typedef enum logic [1:0] {
    LK_CLOSED = 2'd0,
    LK_HALF   = 2'd1,
    LK_OPEN   = 2'd2
  } lock_e;

  function automatic logic react_code_ok(input logic [31:0] w);
    return (w == 32'(REACT_RESET)) || (w == 32'(REACT_IRQ));
  endfunction

endpackage

// File: rtl/kwdt_lock.sv
module kwdt_lock
  import kwdt_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_en_i,
  input  logic [2:0]  idx_i,
  input  logic [31:0] wdata_i,
  output lock_e       state_o,
  output logic        open_o
);

  lock_e state_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= LK_CLOSED;
    end else if (wr_en_i && idx_i == IDX_KICK_A) begin
      state_q <= (wdata_i == KICK_A_WORD) ? LK_HALF : LK_CLOSED;
    end else if (wr_en_i && idx_i == IDX_KICK_B) begin
      state_q <= (state_q == LK_HALF && wdata_i == KICK_B_WORD) ? LK_OPEN : LK_CLOSED;
    end
  end

  assign state_o = state_q;
  assign open_o  = (state_q == LK_OPEN);

endmodule

// File: rtl/kwdt_cfg.sv
module kwdt_cfg
  import kwdt_pkg::*;
#(
  parameter int PRE_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [2:0]       idx_i,
  input  logic [31:0]      wdata_i,
  input  logic             open_i,
  output logic [1:0]       ticksel_o,
  output logic [3:0]       react_o,
  output logic [PRE_W-1:0] preload_o,
  output logic             running_o,
  output logic             start_o
);

  logic cfg_we;
  assign cfg_we  = wr_en_i && open_i;
  assign start_o = cfg_we && idx_i == IDX_RUN && wdata_i == RUN_CODE && !running_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ticksel_o <= 2'd3;
      react_o   <= REACT_RESET;
      preload_o <= '0;
      running_o <= 1'b0;
    end else begin
      if (cfg_we && idx_i == IDX_TICKSEL) ticksel_o <= wdata_i[1:0];
      if (cfg_we && idx_i == IDX_REACT && react_code_ok(wdata_i)) react_o <= wdata_i[3:0];
      if (cfg_we && idx_i == IDX_PRELOAD) preload_o <= wdata_i[PRE_W-1:0];
      if (start_o) running_o <= 1'b1;
    end
  end

endmodule

// File: rtl/kwdt_counter.sv
module kwdt_counter #(
  parameter int PRE_W = 12,
  parameter int SHIFT = 13,
  localparam int CNT_W = PRE_W + SHIFT + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [PRE_W-1:0] preload_i,
  input  logic             tick_i,
  input  logic             running_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             expire_o
);

  function automatic logic [CNT_W-1:0] reload_of(input logic [PRE_W-1:0] p);
    return (CNT_W'(p) + CNT_W'(1)) << SHIFT;
  endfunction

  assign expire_o = running_i && tick_i && (cnt_o == CNT_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_o <= '0;
    end else if (start_i) begin
      cnt_o <= reload_of(preload_i);
    end else if (running_i && tick_i && cnt_o != '0) begin
      cnt_o <= cnt_o - CNT_W'(1);
    end
  end

endmodule

// File: rtl/kwdt_top.sv
module kwdt_top
  import kwdt_pkg::*;
#(
  parameter int PRE_W = 12,
  parameter int SHIFT = 13,
  localparam int CNT_W = PRE_W + SHIFT + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  input  logic [3:0]        tick_i,
  output logic              irq_o,
  output logic              rst_req_o
);

  logic [2:0]       idx_w;
  lock_e            lock_w;
  logic             open_w;
  logic [1:0]       ticksel_w;
  logic [3:0]       react_w;
  logic [PRE_W-1:0] preload_w;
  logic             run_w;
  logic             start_w;
  logic             tick_w;
  logic [CNT_W-1:0] cnt_w;
  logic             expire_w;

  assign idx_w  = addr_i[4:2];
  assign tick_w = tick_i[ticksel_w];

  kwdt_lock u_lock (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .idx_i(idx_w),
    .wdata_i(wdata_i), .state_o(lock_w), .open_o(open_w)
  );

  kwdt_cfg #(.PRE_W(PRE_W)) u_cfg (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .idx_i(idx_w),
    .wdata_i(wdata_i), .open_i(open_w), .ticksel_o(ticksel_w), .react_o(react_w),
    .preload_o(preload_w), .running_o(run_w), .start_o(start_w)
  );

  kwdt_counter #(.PRE_W(PRE_W), .SHIFT(SHIFT)) u_cnt (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_w), .preload_i(preload_w),
    .tick_i(tick_w), .running_i(run_w), .cnt_o(cnt_w), .expire_o(expire_w)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_o     <= 1'b0;
      rst_req_o <= 1'b0;
    end else begin
      rst_req_o <= expire_w && (react_w == REACT_RESET);
      if (expire_w && react_w == REACT_IRQ) irq_o <= 1'b1;
    end
  end

  always_comb begin
    case (idx_w)
      IDX_KICK_A, IDX_KICK_B: rdata_o = {30'd0, lock_w};
      IDX_TICKSEL:            rdata_o = {30'd0, ticksel_w};
      IDX_RUN:                rdata_o = run_w ? RUN_CODE : STOP_CODE;
      IDX_REACT:              rdata_o = {28'd0, react_w};
      IDX_PRELOAD:            rdata_o = 32'(preload_w);
      default:                rdata_o = '0;
    endcase
  end

endmodule

// File: rtl/kwdt_chk.sv
module kwdt_chk
  import kwdt_pkg::*;
#(
  parameter int PRE_W = 12,
  parameter int CNT_W = 26
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_en_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic              open_w,
  input logic [PRE_W-1:0]  preload_w,
  input logic              run_w,
  input logic              start_w,
  input logic              tick_w,
  input logic [CNT_W-1:0]  cnt_w,
  input logic              expire_w,
  input logic              irq_o,
  input logic              rst_req_o
);

  // R1
  locked_preload_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i[4:2] == IDX_PRELOAD && !open_w) |=> $stable(preload_w));

  // R4
  run_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_w |=> run_w);

  // R6
  count_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_w && tick_w && cnt_w != '0 && !start_w) |=> cnt_w == $past(cnt_w) - CNT_W'(1));

  // R6
  expire_running_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expire_w |-> run_w);

  // R7
  rst_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_o |=> !rst_req_o);

  // R8
  irq_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |=> irq_o);

  // R7
  react_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({irq_o, rst_req_o}));

endmodule

bind kwdt_top kwdt_chk #(.PRE_W(PRE_W), .CNT_W(CNT_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .addr_i(addr_i),
  .open_w(open_w), .preload_w(preload_w), .run_w(run_w), .start_w(start_w),
  .tick_w(tick_w), .cnt_w(cnt_w), .expire_w(expire_w), .irq_o(irq_o),
  .rst_req_o(rst_req_o)
);

// File: tb/kwdt_top_tb.sv
module kwdt_top_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [4:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq, rst_req;
  logic        half_mode = 1'b0;
  logic        half_tick = 1'b0;
  logic [3:0]  tick;
  int          total = 0;
  int          failed = 0;
  bit          done = 1'b0;

  localparam logic [4:0] A_KA = 5'h00, A_KB = 5'h04, A_SEL = 5'h08,
                         A_RUN = 5'h0C, A_REACT = 5'h10, A_PRE = 5'h14;
  localparam logic [31:0] KA = 32'h68EF3490, KB = 32'hD172BC5A,
                          GO = 32'hA98559DA, HALT = 32'h5312ACED;

  always #10 clk = ~clk;
  always @(posedge clk) half_tick <= ~half_tick;
  assign tick = half_mode ? {1'b1, 1'b0, half_tick, 1'b0} : 4'b1111;

  kwdt_top u_dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .tick_i(tick), .irq_o(irq), .rst_req_o(rst_req)
  );

  function automatic int timeout_of(input int p);
    return (p + 1) * 8192;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      failed++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic do_reset();
    rst_n = 1'b0; half_mode = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic unlock();
    wr(A_KA, KA);
    wr(A_KB, KB);
  endtask

  task automatic t_reset_state();
    logic [31:0] v;
    do_reset();
    rd(A_KA, v);    chk("R1 lock status at reset", v, 32'd0);
    rd(A_SEL, v);   chk("R9 tick select at reset", v, 32'd3);
    rd(A_RUN, v);   chk("R3 run reg at reset", v, HALT);
    rd(A_REACT, v); chk("R5 reaction at reset", v, 32'h5);
    rd(A_PRE, v);   chk("R6 preload at reset", v, 32'd0);
    chk("R7 outputs at reset", {30'd0, irq, rst_req}, 32'd0);
  endtask

  task automatic t_lock();
    logic [31:0] v;
    do_reset();
    wr(A_PRE, 32'd7);
    wr(A_REACT, 32'hA);
    rd(A_PRE, v);   chk("R1 preload ignored while locked", v, 32'd0);
    rd(A_REACT, v); chk("R1 reaction ignored while locked", v, 32'h5);
    wr(A_KA, KA);
    rd(A_KB, v);    chk("R2 half-unlocked", v, 32'd1);
    wr(A_KB, KB);
    rd(A_KA, v);    chk("R2 open", v, 32'd2);
    wr(A_PRE, 32'd7);
    rd(A_PRE, v);   chk("R1 preload accepted when open", v, 32'd7);
    wr(A_KB, KB ^ 32'h1);
    rd(A_KA, v);    chk("R2 wrong second word relocks", v, 32'd0);
    wr(A_PRE, 32'd9);
    rd(A_PRE, v);   chk("R1 preload ignored after relock", v, 32'd7);
    wr(A_KB, KB);
    rd(A_KA, v);    chk("R2 out-of-order stays locked", v, 32'd0);
    wr(A_KA, KA); wr(A_KA, KA); wr(A_KB, KB);
    rd(A_KA, v);    chk("R2 repeated first word then second opens", v, 32'd2);
    wr(A_KA, 32'h0);
    rd(A_KA, v);    chk("R2 wrong first word relocks", v, 32'd0);
  endtask

  task automatic t_react_ctrl();
    logic [31:0] v;
    do_reset();
    unlock();
    wr(A_REACT, 32'h6);
    rd(A_REACT, v); chk("R5 invalid code ignored", v, 32'h5);
    wr(A_REACT, 32'hA);
    rd(A_REACT, v); chk("R5 code A accepted", v, 32'hA);
    wr(A_REACT, 32'h1000_0005);
    rd(A_REACT, v); chk("R5 high bits make code invalid", v, 32'hA);
    wr(A_REACT, 32'h5);
    rd(A_REACT, v); chk("R5 code 5 accepted", v, 32'h5);
    wr(A_RUN, GO ^ 32'h8000_0000);
    rd(A_RUN, v);   chk("R3 near-miss run code ignored", v, HALT);
    wr(A_RUN, HALT);
    rd(A_RUN, v);   chk("R3 stop code while idle", v, HALT);
    wr(A_SEL, 32'd1);
    rd(A_SEL, v);   chk("R9 tick select write", v, 32'd1);
  endtask

  task automatic t_timeout_reset(input int p);
    int first = -1;
    int width = 0;
    int irq_seen = 0;
    int n = timeout_of(p);
    do_reset();
    unlock();
    wr(A_PRE, 32'(p));
    wr(A_RUN, GO);
    for (int k = 1; k <= n + 6; k++) begin
      @(negedge clk);
      if (rst_req) begin
        width++;
        if (first < 0) first = k;
      end
      if (irq) irq_seen++;
    end
    chk("R6 expiry cycle", 32'(first), 32'(n));
    chk("R7 reset pulse width", 32'(width), 32'd1);
    chk("R7 irq stays low", 32'(irq_seen), 32'd0);
  endtask

  task automatic t_irq_nostop();
    logic [31:0] v;
    int first = -1;
    int pulses = 0;
    int lows_after = 0;
    int n = timeout_of(1);
    do_reset();
    unlock();
    wr(A_PRE, 32'd1);
    wr(A_REACT, 32'hA);
    wr(A_RUN, GO);
    wr(A_RUN, HALT);
    rd(A_RUN, v); chk("R4 stop code ignored while running", v, GO);
    for (int k = 1; k <= n + 40; k++) begin
      @(negedge clk);
      if (rst_req) pulses++;
      if (irq && first < 0) first = k;
      if (first >= 0 && !irq) lows_after++;
    end
    chk("R4 runs to expiry despite stop", 32'(first > 0), 32'd1);
    chk("R8 irq held", 32'(lows_after), 32'd0);
    chk("R8 no reset pulse", 32'(pulses), 32'd0);
    do_reset();
    chk("R8 irq cleared by reset", {31'd0, irq}, 32'd0);
  endtask

  task automatic t_ticksel();
    int first = -1;
    int n = timeout_of(0);
    do_reset();
    unlock();
    wr(A_SEL, 32'd1);
    half_mode = 1'b1;
    wr(A_RUN, GO);
    for (int k = 1; k <= 2 * n + 10; k++) begin
      @(negedge clk);
      if (rst_req && first < 0) first = k;
    end
    chk("R9 half-rate tick expiry not early", 32'(first >= 2 * n - 2), 32'd1);
    chk("R9 half-rate tick expiry not late", 32'(first > 0 && first <= 2 * n + 2), 32'd1);
    half_mode = 1'b0;
  endtask

  initial begin
    t_reset_state();
    t_lock();
    t_react_ctrl();
    t_timeout_reset(0);
    t_timeout_reset(1);
    t_irq_nostop();
    t_ticksel();
    done = 1'b1;
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++;
      failed++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("%0d/%0d checks passed", total - failed, total);
      $finish;
    end
  end

endmodule